// File: doc/BRIEF.md
# Phase Short-Circuit Monitor with Fault Latch

This block watches a three-phase half-bridge power stage from the logic side. For each phase it takes the two gate enables the controller issues (upper and lower switch) and a synchronized digital sample of the actual phase output level. When a phase is commanded to a definite level and the observed level disagrees, a short-circuit mismatch is raised for that phase. A mismatch is raised only once a blanking window has passed since that phase's gate enables last changed, so that normal output transitions are not reported.

The combined short-circuit flag is only a report and gates nothing. It and an already synchronized over-temperature input feed a separate fault latch. The latch output is the hard-wired disable for every output of the stage. The latch is cleared only by an explicit clear pulse from the controller, so no software is needed to shut the stage down. A one-cycle interrupt pulse marks each time the latch is set.

Top module: `phase_fault_guard`

## Requirements
- R1: While `rst_n` is low, every output is low at the next clock edge, and the latch starts clear.
- R2: A phase with only its upper enable set expects an output level of 1. A phase with only its lower enable set expects 0. With both enables off or both on, that phase is never compared and raises no mismatch.
- R3: A phase outside blanking whose sampled level differs from the expected level at a clock edge drives `short_flag` high from that edge. The flag stays high for as long as the mismatch is sampled, and drops at the first edge where it is gone.
- R4: Any change in a phase's gate enables starts a blanking window for that phase. No mismatch is raised at the edge that samples the change, nor at the BLANK_CYCLES edges that follow. A further change restarts the window.
- R5: `short_flag` is the OR of the per-phase mismatches. Each phase keeps its own blanking, and the flag stays high while any phase still mismatches.
- R6: At the edge after `short_flag` or `overtemp` is high, the latch is set and `disable_all` is high.
- R7: Once set, the latch holds through the removal of every fault source. Only a cycle with `clear_req` high and no active fault source clears it, at that edge.
- R8: If `clear_req` is high while `short_flag` or `overtemp` is high, setting wins and `disable_all` stays high.
- R9: `fault_irq` is high for exactly the one cycle in which the latch has just gone from clear to set.
- R10: `short_flag` keeps following the mismatch state whether or not the latch is set; the flag never disables the stage by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_hi | input | NUM_PH | Upper-switch enable per phase |
| gate_lo | input | NUM_PH | Lower-switch enable per phase |
| out_level | input | NUM_PH | Synchronized observed output level per phase |
| overtemp | input | 1 | Synchronized over-temperature indication |
| clear_req | input | 1 | Controller pulse that clears the fault latch |
| short_flag | output | 1 | Short-circuit report, OR of phase mismatches |
| disable_all | output | 1 | Latched disable for all outputs |
| fault_irq | output | 1 | One-cycle pulse when the latch sets |

## Verification
The assertions check, on every cycle, the relations that span one edge. These are: a fault source setting the latch, the latch holding without a clear, set winning over clear, the interrupt marking only a fresh set, no mismatch on a don't-care command, and no mismatch at the edge of a command change. Only the bench scenarios can show the exact length of the blanking window and its restart on a second change, that a mismatch persists and then clears, and that one phase keeps the flag high after another is fixed. These rely on counting many cycles against a reference model.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
// Package: shared command encoding for the phase fault guard.
// Assumes each phase is driven by one upper and one lower gate enable.
package pfg_pkg;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_LOW  = 2'b01,
        DRV_HIGH = 2'b10,
        DRV_BOTH = 2'b11
    } drive_e;

    // Pack the two enables of one phase into the drive encoding.
    function automatic drive_e to_drive(input logic hi, input logic lo);
        return drive_e'({hi, lo});
    endfunction

    // A command has a defined output level only when exactly one switch is on.
    function automatic logic level_defined(input drive_e d);
        return (d == DRV_HIGH) || (d == DRV_LOW);
    endfunction

    // Level the output must show for a defined command.
    function automatic logic level_expected(input drive_e d);
        return (d == DRV_HIGH);
    endfunction

endpackage

// File: rtl/pfg_phase_mon.sv
`timescale 1ns/1ps
// Module: per-phase mismatch detector.
// Compares the commanded drive of one phase with its observed output level.
// A mismatch is registered only once BLANK_CYCLES edges have passed since
// the last change of the gate enables. Assumes out_level is already
// synchronized to clk.
module pfg_phase_mon
    import pfg_pkg::*;
#(
    parameter int BLANK_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic out_level,
    output logic mismatch
);
    localparam int CNT_W = $clog2(BLANK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYCLES);

    drive_e          drv_now;
    drive_e          drv_prev;
    logic            drv_changed;
    logic [CNT_W-1:0] blank_cnt;
    logic            compare_ok;

    // Decode the present command and detect a change against last cycle.
    always_comb begin
        drv_now     = to_drive(cmd_hi, cmd_lo);
        drv_changed = (drv_now != drv_prev);
        compare_ok  = !drv_changed && (blank_cnt == '0) && level_defined(drv_now);
    end

    // Remember the previous command for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_prev <= DRV_OFF;
        else        drv_prev <= drv_now;
    end

    // Blanking counter: reload on a command change, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              blank_cnt <= '0;
        else if (drv_changed)    blank_cnt <= CNT_LOAD;
        else if (blank_cnt != '0) blank_cnt <= blank_cnt - CNT_W'(1);
    end

    // Register the mismatch decision for this phase.
    always_ff @(posedge clk) begin
        if (!rst_n) mismatch <= 1'b0;
        else        mismatch <= compare_ok && (out_level != level_expected(drv_now));
    end

endmodule

// File: rtl/pfg_fault_latch.sv
`timescale 1ns/1ps
// Module: sticky fault latch with set priority.
// Sets on either fault source, clears only on clear_req when no source is
// active, and emits a one-cycle pulse on each clear-to-set transition.
module pfg_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_short,
    input  logic set_temp,
    input  logic clear_req,
    output logic latched,
    output logic set_pulse
);
    logic set_any;

    // Either fault source requests the latch to set.
    always_comb set_any = set_short || set_temp;

    // Latch state: set wins over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         latched <= 1'b0;
        else if (set_any)   latched <= 1'b1;
        else if (clear_req) latched <= 1'b0;
    end

    // Interrupt pulse in the cycle the latch first becomes set.
    always_ff @(posedge clk) begin
        if (!rst_n) set_pulse <= 1'b0;
        else        set_pulse <= set_any && !latched;
    end

endmodule

// File: rtl/phase_fault_guard.sv
`timescale 1ns/1ps
// Module: top of the short-circuit monitor with fault latch.
// One mismatch detector per phase feeds a reporting flag. The flag and the
// over-temperature input set a latch that drives the global disable.
// Assumes all inputs are synchronous to clk.
module phase_fault_guard #(
    parameter int NUM_PH       = 3,
    parameter int BLANK_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] gate_hi,
    input  logic [NUM_PH-1:0] gate_lo,
    input  logic [NUM_PH-1:0] out_level,
    input  logic              overtemp,
    input  logic              clear_req,
    output logic              short_flag,
    output logic              disable_all,
    output logic              fault_irq
);
    logic [NUM_PH-1:0] phase_mis;

    // One detector instance per phase.
    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        pfg_phase_mon #(
            .BLANK_CYCLES(BLANK_CYCLES)
        ) mon_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_hi   (gate_hi[p]),
            .cmd_lo   (gate_lo[p]),
            .out_level(out_level[p]),
            .mismatch (phase_mis[p])
        );
    end

    // Combine the phase detectors into the reported flag.
    always_comb short_flag = |phase_mis;

    pfg_fault_latch latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_short(short_flag),
        .set_temp (overtemp),
        .clear_req(clear_req),
        .latched  (disable_all),
        .set_pulse(fault_irq)
    );

endmodule

// File: rtl/pfg_checker.sv
`timescale 1ns/1ps
// Module: assertion checker bound to phase_fault_guard.
module pfg_checker #(
    parameter int NUM_PH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PH-1:0] gate_hi,
    input logic [NUM_PH-1:0] gate_lo,
    input logic              overtemp,
    input logic              clear_req,
    input logic              short_flag,
    input logic              disable_all,
    input logic              fault_irq,
    input logic [NUM_PH-1:0] phase_mis
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!disable_all && !short_flag && !fault_irq)); // R1

    AST_FLAG_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        short_flag |=> disable_all); // R6

    AST_TEMP_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp |=> disable_all); // R6

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_all && !clear_req) |=> disable_all); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && (short_flag || overtemp)) |=> disable_all); // R8

    AST_IRQ_ON_FRESH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |-> (disable_all && !$past(disable_all))); // R9

    for (genvar p = 0; p < NUM_PH; p++) begin : g_chk
        AST_NO_FLAG_DONTCARE: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_hi[p] == gate_lo[p]) |=> !phase_mis[p]); // R2

        AST_NO_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ((gate_hi[p] != $past(gate_hi[p])) || (gate_lo[p] != $past(gate_lo[p])))
            |=> !phase_mis[p]); // R4
    end
endmodule

bind phase_fault_guard pfg_checker #(.NUM_PH(NUM_PH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .overtemp   (overtemp),
    .clear_req  (clear_req),
    .short_flag (short_flag),
    .disable_all(disable_all),
    .fault_irq  (fault_irq),
    .phase_mis  (phase_mis)
);

// File: tb/phase_fault_guard_tb_top.sv
`timescale 1ns/1ps
module phase_fault_guard_tb_top;
    localparam int NP = 3;
    localparam int BL = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] gh = '0, gl = '0, fb = '0;
    logic          ot = 1'b0, clr = 1'b0;
    logic          flag, dis, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 20 ns period, 50 MHz

    phase_fault_guard #(.NUM_PH(NP), .BLANK_CYCLES(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .gate_hi(gh), .gate_lo(gl), .out_level(fb),
        .overtemp(ot), .clear_req(clr), .short_flag(flag),
        .disable_all(dis), .fault_irq(irq)
    );

    // Behavioural reference model, advanced on every rising edge.
    bit m_hi[NP], m_lo[NP], m_mis[NP];
    int m_age[NP];
    bit m_latch, m_irq;

    always @(posedge clk) begin
        bit any_mis;
        any_mis = 1'b0;
        for (int p = 0; p < NP; p++) any_mis |= m_mis[p];
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_hi[p] = 0; m_lo[p] = 0; m_mis[p] = 0; m_age[p] = BL;
            end
            m_latch = 0; m_irq = 0;
        end else begin
            m_irq = (any_mis || ot) && !m_latch;
            if (any_mis || ot) m_latch = 1;
            else if (clr)      m_latch = 0;
            for (int p = 0; p < NP; p++) begin
                bit chg;
                chg = (gh[p] != m_hi[p]) || (gl[p] != m_lo[p]);
                m_mis[p] = !chg && (m_age[p] >= BL) && (gh[p] != gl[p]) && (fb[p] != gh[p]);
                if (chg) m_age[p] = 0;
                else if (m_age[p] < BL) m_age[p]++;
                m_hi[p] = gh[p]; m_lo[p] = gl[p];
            end
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Compare every output with the model between edges.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit any_mis;
            any_mis = 1'b0;
            for (int p = 0; p < NP; p++) any_mis |= m_mis[p];
            check("R3", "short_flag vs model", flag, any_mis);
            check("R6", "disable_all vs model", dis, m_latch);
            check("R9", "fault_irq vs model", irq, m_irq);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        tick(3);
        check("R1", "flag in reset", flag, 1'b0);
        check("R1", "disable in reset", dis, 1'b0);
        check("R1", "irq in reset", irq, 1'b0);
        rst_n = 1'b1;

        // R2: all phases off, arbitrary levels give no flag
        fb = 3'b101; tick(5);
        check("R2", "off phases ignored", flag, 1'b0);

        // Phase 0 high and matching
        gh[0] = 1; fb[0] = 1; tick(40);
        check("R2", "matching high", flag, 1'b0);

        // R4/R3: phase 1 low but output high
        gl[1] = 1; fb[1] = 1; tick(1);
        tick(BL);
        check("R4", "still blanked at last window edge", flag, 1'b0);
        tick(1);
        check("R3", "flag after window", flag, 1'b1);
        check("R10", "flag does not disable same cycle", dis, 1'b0);
        tick(1);
        check("R6", "latch set", dis, 1'b1);
        check("R9", "irq pulse", irq, 1'b1);
        check("R10", "flag follows mismatch while latched", flag, 1'b1);
        tick(1);
        check("R9", "irq single cycle", irq, 1'b0);

        // R7: mismatch gone, latch holds
        fb[1] = 0; tick(1);
        check("R3", "flag drops", flag, 1'b0);
        tick(3);
        check("R7", "latch holds", dis, 1'b1);
        clr = 1; tick(1); clr = 0;
        check("R7", "clear works", dis, 1'b0);

        // R6/R8: overtemp with simultaneous clear
        ot = 1; tick(1);
        check("R6", "overtemp sets", dis, 1'b1);
        clr = 1; tick(2);
        check("R8", "set beats clear", dis, 1'b1);
        ot = 0; tick(1); clr = 0;
        check("R7", "clear after source gone", dis, 1'b0);

        // R4: restart of the blanking window
        gh[2] = 1; fb[2] = 0; tick(20);
        gh[2] = 0; tick(1);
        gh[2] = 1; tick(1);
        tick(20);
        check("R4", "window restarted", flag, 1'b0);
        tick(13);
        check("R3", "flag after restarted window", flag, 1'b1);
        fb[2] = 1; tick(1);
        clr = 1; tick(1); clr = 0;
        check("R7", "cleared", dis, 1'b0);

        // R5: two phases mismatch, fix one
        fb[0] = 0; fb[1] = 1; tick(1);
        check("R5", "two phases flag", flag, 1'b1);
        fb[0] = 1; tick(1);
        check("R5", "one phase keeps flag", flag, 1'b1);
        fb[1] = 0; tick(1);
        check("R5", "flag clears when all fixed", flag, 1'b0);
        clr = 1; tick(1); clr = 0;

        // R2: both switches on is never compared
        gl[0] = 1;
        for (int i = 0; i < 40; i++) begin
            fb[0] = i[0]; tick(1);
        end
        check("R2", "both-on ignored", flag, 1'b0);
        check("R2", "latch untouched", dis, 1'b0);

        tick(2);
        report();
    end
endmodule